// File: doc/BRIEF.md
# Interrupt Request and In-Service Tracker

This block keeps the pending and in-service state for a 256-entry interrupt vector space. Two bit arrays hold this state: a request array, whose bits mark vectors that wait for service, and an in-service array, whose bits mark vectors that a core has taken and not yet retired. Each array is split into eight 32-bit words. Vector v sits in word v/32 at bit v%32. Request ports set request bits. An accept pulse moves the highest pending vector into the in-service array. An end-of-service pulse retires the highest in-service vector.

Both arrays feed a priority resolver. The resolver reports the highest set vector at all times and reports 0 when the array is empty. Five non-vectored sources are held outside the arrays. These are system management, non-maskable, external controller, processor init and startup. Each has its own pending flag, a captured 8-bit vector and an acknowledge input. A combined output flags any pending source that cannot be masked. The external-controller source is left out of that flag. Gating by task priority and register access from a bus are handled by the surrounding logic.

Top module: `irq_vec_tracker`

## Requirements
- R1: A request with valid high on any request port sets the bit for its vector v, at word v/32 and bit v%32. The highest-request output reflects the new bit one cycle later.
- R2: Each highest-vector output equals 32 times the index of the uppermost non-zero word, plus the position of the most significant set bit in that word.
- R3: When an array holds no set bit, its highest-vector output is 0.
- R4: Requesting a vector that is already pending, or requesting one vector on both ports in the same cycle, leaves a single pending bit. One accept then removes it.
- R5: An accept while the request array is non-empty clears the highest request bit and sets the same in-service bit, both in the same clock edge.
- R6: An accept while the request array is empty changes neither array.
- R7: An end-of-service pulse clears the highest set in-service bit. It has no effect when the in-service array is empty. If accept fires in the same cycle, the accepted bit is still set.
- R8: Each special source (index 0 system management, 1 non-maskable, 2 external controller, 3 init, 4 startup) sets its pending flag on its set input and captures its 8-bit vector in the same edge. Its own acknowledge clears the flag. If set and acknowledge arrive in the same cycle, set wins.
- R9: The unmaskable-pending output is high when any of sources 0, 1, 3 or 4 is pending. Source 2 alone leaves it low.
- R10: When a request names the vector being accepted in the same cycle, that vector stays pending in the request array and is also set in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 2 | Per-port request strobe |
| req_vec_i | input | 16 | Request vectors, port p in bits [8p+7:8p] |
| accept_i | input | 1 | Move the highest pending vector into service |
| eoi_i | input | 1 | Retire the highest in-service vector |
| spc_set_i | input | 5 | Per-source pending set |
| spc_vec_i | input | 40 | Per-source vector, source s in bits [8s+7:8s] |
| spc_ack_i | input | 5 | Per-source acknowledge |
| irr_top_o | output | 8 | Highest pending vector, 0 when empty |
| isr_top_o | output | 8 | Highest in-service vector, 0 when empty |
| spc_pend_o | output | 5 | Per-source pending flags |
| spc_vec_o | output | 40 | Per-source captured vectors |
| unmaskable_o | output | 1 | Any unmaskable special source pending |

## Verification
Every stimulus is applied on a falling edge and takes effect at the next rising edge. The flags, the captured vectors and both highest-vector outputs can all be read a short delay after that rising edge, because the resolvers are combinational from the array registers. The driver computes the expected values from its own model of both arrays and pushes them into a queue in the same half-cycle as the stimulus. The monitor pops one entry per rising edge, just after that edge, so each comparison lands on the cycle in which the result is due.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int VEC_W     = 8;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int NUM_REQ   = 2;
  localparam int NUM_SRC   = 5;

  typedef enum logic [2:0] {
    SRC_SMI   = 3'd0,
    SRC_NMI   = 3'd1,
    SRC_EXT   = 3'd2,
    SRC_INIT  = 3'd3,
    SRC_START = 3'd4
  } src_e;

  // sources that count toward the unmaskable flag (external excluded)
  localparam logic [NUM_SRC-1:0] UNMASK_SRCS = 5'b11011;
endpackage

// File: rtl/irq_vec_array.sv
module irq_vec_array #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 32,
  localparam int N        = NUM_WORDS * WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] bits_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else         word_q <= (word_q & ~clr_i[w*WORD_W +: WORD_W]) | set_i[w*WORD_W +: WORD_W];
    end
    assign bits_o[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/irq_msb_resolver.sv
module irq_msb_resolver #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 32,
  parameter int VEC_W     = 8,
  localparam int N        = NUM_WORDS * WORD_W,
  localparam int BIT_W    = $clog2(WORD_W)
) (
  input  logic [N-1:0]     bits_i,
  output logic [VEC_W-1:0] top_o,
  output logic             any_o
);
  logic [NUM_WORDS-1:0] word_nz;
  logic [BIT_W-1:0]     word_msb [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign word_nz[w] = |bits_i[w*WORD_W +: WORD_W];
    always_comb begin
      word_msb[w] = '0;
      for (int b = 0; b < WORD_W; b++)
        if (bits_i[w*WORD_W + b]) word_msb[w] = BIT_W'(b);
    end
  end

  // ascending scan: uppermost non-zero word wins
  always_comb begin
    top_o = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (word_nz[w]) top_o = VEC_W'(w * WORD_W + int'(word_msb[w]));
  end

  assign any_o = |word_nz;
endmodule

// File: rtl/irq_special_src.sv
module irq_special_src #(
  parameter int NUM_SRC = 5,
  parameter int VEC_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       set_i,
  input  logic [NUM_SRC*VEC_W-1:0] vec_i,
  input  logic [NUM_SRC-1:0]       ack_i,
  output logic [NUM_SRC-1:0]       pend_o,
  output logic [NUM_SRC*VEC_W-1:0] vec_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic             pend_q;
    logic [VEC_W-1:0] vec_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        vec_q  <= '0;
      end else begin
        if (set_i[s]) begin
          pend_q <= 1'b1;
          vec_q  <= vec_i[s*VEC_W +: VEC_W];
        end else if (ack_i[s]) begin
          pend_q <= 1'b0;
        end
      end
    end
    assign pend_o[s]               = pend_q;
    assign vec_o[s*VEC_W +: VEC_W] = vec_q;

    assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[s] && !set_i[s] |=> !pend_o[s]);
    assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[s] |=> pend_o[s] && vec_o[s*VEC_W +: VEC_W] == $past(vec_i[s*VEC_W +: VEC_W]));
  end
endmodule

// File: rtl/irq_vec_tracker.sv
module irq_vec_tracker
  import irq_trk_pkg::*;
#(
  parameter int P_VEC_W     = VEC_W,
  parameter int P_WORD_W    = WORD_W,
  parameter int P_NUM_WORDS = NUM_WORDS,
  parameter int P_NUM_REQ   = NUM_REQ,
  parameter int P_NUM_SRC   = NUM_SRC,
  localparam int N          = P_NUM_WORDS * P_WORD_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [P_NUM_REQ-1:0]         req_valid_i,
  input  logic [P_NUM_REQ*P_VEC_W-1:0] req_vec_i,
  input  logic                         accept_i,
  input  logic                         eoi_i,
  input  logic [P_NUM_SRC-1:0]         spc_set_i,
  input  logic [P_NUM_SRC*P_VEC_W-1:0] spc_vec_i,
  input  logic [P_NUM_SRC-1:0]         spc_ack_i,
  output logic [P_VEC_W-1:0]           irr_top_o,
  output logic [P_VEC_W-1:0]           isr_top_o,
  output logic [P_NUM_SRC-1:0]         spc_pend_o,
  output logic [P_NUM_SRC*P_VEC_W-1:0] spc_vec_o,
  output logic                         unmaskable_o
);
  logic [N-1:0] irr_bits, isr_bits, req_set, acc_mask, eoi_mask;
  logic         irr_any, isr_any, acc_fire, eoi_fire;

  always_comb begin
    req_set = '0;
    for (int p = 0; p < P_NUM_REQ; p++)
      if (req_valid_i[p]) req_set[req_vec_i[p*P_VEC_W +: P_VEC_W]] = 1'b1;
  end

  assign acc_fire = accept_i & irr_any;
  assign eoi_fire = eoi_i & isr_any;
  assign acc_mask = acc_fire ? (N'(1) << irr_top_o) : '0;
  assign eoi_mask = eoi_fire ? (N'(1) << isr_top_o) : '0;

  irq_vec_array #(.NUM_WORDS(P_NUM_WORDS), .WORD_W(P_WORD_W)) u_irr (
    .clk_i, .rst_ni, .set_i(req_set), .clr_i(acc_mask), .bits_o(irr_bits));

  irq_vec_array #(.NUM_WORDS(P_NUM_WORDS), .WORD_W(P_WORD_W)) u_isr (
    .clk_i, .rst_ni, .set_i(acc_mask), .clr_i(eoi_mask), .bits_o(isr_bits));

  irq_msb_resolver #(.NUM_WORDS(P_NUM_WORDS), .WORD_W(P_WORD_W), .VEC_W(P_VEC_W)) u_irr_res (
    .bits_i(irr_bits), .top_o(irr_top_o), .any_o(irr_any));

  irq_msb_resolver #(.NUM_WORDS(P_NUM_WORDS), .WORD_W(P_WORD_W), .VEC_W(P_VEC_W)) u_isr_res (
    .bits_i(isr_bits), .top_o(isr_top_o), .any_o(isr_any));

  irq_special_src #(.NUM_SRC(P_NUM_SRC), .VEC_W(P_VEC_W)) u_spc (
    .clk_i, .rst_ni, .set_i(spc_set_i), .vec_i(spc_vec_i), .ack_i(spc_ack_i),
    .pend_o(spc_pend_o), .vec_o(spc_vec_o));

  assign unmaskable_o = |(spc_pend_o & UNMASK_SRCS);

  assert_req_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i[0] |=> irr_bits[$past(req_vec_i[P_VEC_W-1:0])]);
  assert_top_is_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irr_any |-> irr_bits[irr_top_o] && (irr_bits >> irr_top_o) == N'(1));
  assert_empty_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irr_bits == '0 |-> irr_top_o == '0) and (isr_bits == '0 |-> isr_top_o == '0));
  assert_accept_moves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fire |=> isr_bits[$past(irr_top_o)]);
  assert_accept_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irr_any && !eoi_i |=> $stable(isr_bits));
  assert_eoi_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_fire && !accept_i |=> !isr_bits[$past(isr_top_o)]);
  assert_unmask_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unmaskable_o) |-> $past(|(spc_set_i & UNMASK_SRCS)));
endmodule

// File: tb/irq_vec_tracker_test.sv
module irq_vec_tracker_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_valid = '0;
  logic [15:0] req_vec = '0;
  logic        accept = 1'b0, eoi = 1'b0;
  logic [4:0]  spc_set = '0, spc_ack = '0;
  logic [39:0] spc_vec = '0;
  logic [7:0]  irr_top, isr_top;
  logic [4:0]  spc_pend;
  logic [39:0] spc_vec_q;
  logic        unmask;

  always #(CLK_P/2) clk = ~clk;

  irq_vec_tracker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vec_i(req_vec),
    .accept_i(accept), .eoi_i(eoi), .spc_set_i(spc_set), .spc_vec_i(spc_vec),
    .spc_ack_i(spc_ack), .irr_top_o(irr_top), .isr_top_o(isr_top),
    .spc_pend_o(spc_pend), .spc_vec_o(spc_vec_q), .unmaskable_o(unmask));

  typedef struct {
    string      tag;
    logic [7:0] irr_top, isr_top;
    logic [4:0] pend;
    logic [39:0] vecs;
    logic       unm;
  } exp_t;

  exp_t   q[$];
  int     n_cmp = 0, n_bad = 0;
  bit     done = 0;
  logic [255:0] m_irr = '0, m_isr = '0;
  logic [4:0]   m_pend = '0;
  logic [39:0]  m_vecs = '0;

  function automatic logic [7:0] hi(logic [255:0] b);
    for (int i = 255; i >= 0; i--) if (b[i]) return 8'(i);
    return 8'd0;
  endfunction

  task automatic op(string tag, logic [1:0] rv, logic [7:0] v0, logic [7:0] v1,
                    logic acc, logic eo, logic [4:0] sset, logic [39:0] svec, logic [4:0] sack);
    logic [255:0] amask, emask, smask;
    exp_t e;
    @(negedge clk);
    req_valid = rv; req_vec = {v1, v0}; accept = acc; eoi = eo;
    spc_set = sset; spc_vec = svec; spc_ack = sack;
    amask = (acc && m_irr != '0) ? (256'd1 << hi(m_irr)) : '0;
    emask = (eo && m_isr != '0) ? (256'd1 << hi(m_isr)) : '0;
    smask = '0;
    if (rv[0]) smask[v0] = 1'b1;
    if (rv[1]) smask[v1] = 1'b1;
    m_irr = (m_irr & ~amask) | smask;
    m_isr = (m_isr & ~emask) | amask;
    for (int s = 0; s < 5; s++) begin
      if (sset[s]) begin m_pend[s] = 1'b1; m_vecs[s*8 +: 8] = svec[s*8 +: 8]; end
      else if (sack[s]) m_pend[s] = 1'b0;
    end
    e.tag = tag; e.irr_top = hi(m_irr); e.isr_top = hi(m_isr);
    e.pend = m_pend; e.vecs = m_vecs;
    e.unm = m_pend[0] | m_pend[1] | m_pend[3] | m_pend[4];
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    op(tag, 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 5'd0, 40'd0, 5'd0);
  endtask

  // monitor: one expected item per rising edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_cmp++;
        if (irr_top !== e.irr_top || isr_top !== e.isr_top || spc_pend !== e.pend ||
            spc_vec_q !== e.vecs || unmask !== e.unm) begin
          n_bad++;
          $display("FAIL %s: irr=%0d isr=%0d pend=%b vec=%h unm=%b exp irr=%0d isr=%0d pend=%b vec=%h unm=%b",
                   e.tag, irr_top, isr_top, spc_pend, spc_vec_q, unmask,
                   e.irr_top, e.isr_top, e.pend, e.vecs, e.unm);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    n_cmp++;
    if (irr_top !== 8'd0 || isr_top !== 8'd0 || spc_pend !== 5'd0 || unmask !== 1'b0) begin
      n_bad++;
      $display("FAIL reset R3: irr=%0d isr=%0d pend=%b unm=%b exp 0 0 0 0", irr_top, isr_top, spc_pend, unmask);
    end
    // R4: same vector on both ports, then re-request while pending
    op("R4 dual port", 2'b11, 8'd100, 8'd100, 1'b0, 1'b0, 5'd0, 40'd0, 5'd0);
    op("R4 re-request", 2'b01, 8'd100, 8'd0, 1'b0, 1'b0, 5'd0, 40'd0, 5'd0);
    op("R4 single accept empties", 2'b00, 8'd0, 8'd0, 1'b1, 1'b0, 5'd0, 40'd0, 5'd0);
    // R7: retire vector 100
    op("R7 eoi", 2'b00, 8'd0, 8'd0, 1'b0, 1'b1, 5'd0, 40'd0, 5'd0);
    op("R7 eoi on empty", 2'b00, 8'd0, 8'd0, 1'b0, 1'b1, 5'd0, 40'd0, 5'd0);
    // R6: accept on empty request array
    op("R6 accept on empty", 2'b00, 8'd0, 8'd0, 1'b1, 1'b0, 5'd0, 40'd0, 5'd0);
    // R1 / R2: word mapping and priority across words
    op("R1 vector 37", 2'b01, 8'd37, 8'd0, 1'b0, 1'b0, 5'd0, 40'd0, 5'd0);
    op("R2 across words", 2'b11, 8'd5, 8'd200, 1'b0, 1'b0, 5'd0, 40'd0, 5'd0);
    op("R2 lower in word", 2'b11, 8'd63, 8'd192, 1'b0, 1'b0, 5'd0, 40'd0, 5'd0);
    op("R1 vector 255", 2'b01, 8'd255, 8'd0, 1'b0, 1'b0, 5'd0, 40'd0, 5'd0);
    // R5: move 255 then 200
    op("R5 accept top", 2'b00, 8'd0, 8'd0, 1'b1, 1'b0, 5'd0, 40'd0, 5'd0);
    op("R5 accept next", 2'b00, 8'd0, 8'd0, 1'b1, 1'b0, 5'd0, 40'd0, 5'd0);
    // R7: accept and eoi together
    op("R7 accept with eoi", 2'b00, 8'd0, 8'd0, 1'b1, 1'b1, 5'd0, 40'd0, 5'd0);
    // R10: re-request the vector being accepted
    op("R10 request during accept", 2'b01, 8'd63, 8'd0, 1'b1, 1'b0, 5'd0, 40'd0, 5'd0);
    idle("R10 hold");
    // R8 / R9: special sources
    op("R9 external only", 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 5'b00100, 40'h00_00_7a_00_00, 5'd0);
    op("R8 nmi set", 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 5'b00010, 40'h00_00_00_02_00, 5'd0);
    op("R8 set wins over ack", 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 5'b00010, 40'h00_00_00_44_00, 5'b00010);
    op("R8 ack clears", 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 5'd0, 40'd0, 5'b00010);
    op("R9 startup and init", 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 5'b11001, 40'h9c_0f_00_00_33, 5'd0);
    op("R9 ack all but ext", 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 5'd0, 40'd0, 5'b11011);
    // mixed random traffic against the model
    seed = 7;
    void'($urandom(seed));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      op("R1/R2/R5/R7 random", r[1:0] & {r[2], 1'b1}, 8'($urandom), 8'($urandom),
         r[4:3] == 2'b00, r[6:5] == 2'b00, r[11:7] & r[16:12], 40'({$urandom, $urandom}),
         r[21:17] & r[26:22]);
    end
    for (int i = 0; i < 300; i++)
      op("R3 drain", 2'b00, 8'd0, 8'd0, 1'b1, 1'b1, 5'd0, 40'd0, 5'd0);
    idle("tail");
    @(posedge clk); #2;
    @(posedge clk); #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule